// File: doc/BRIEF.md
# Spindle Commutation State Controller

This block sequences the six-step commutation of a three-phase spindle motor from a few control bits. A run bit turns the power stage on or off. A manual-select bit and a 3-bit code let software set the step directly. When manual mode is off, an advance pulse from an external back-EMF timing stage walks the step forward. The advance pulse is only accepted on a prescaled internal tick, and a 2-bit factor sets that tick's rate.

Stopping the motor does not brake it. All phases float and the step returns to 0, so the next start begins at step 0. Leaving manual mode while the motor keeps running hands control back to automatic stepping at whatever step was last set by hand. While the outputs are off, an enable bit can request that the centre tap be biased at half the supply, so that the back-EMF comparator can still watch a coasting motor.

Every output is registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `spin_commutator`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0, both drive vectors are 0, `off_o` is 1, and `bias_o` and `err_o` are 0. The internal tick counter restarts at 0 on the first edge after release.
- R2: At an edge where `run_i` is 0, the next outputs have `hs_o` = `ls_o` = 0, `off_o` = 1 and `state_o` = 0, with no braking pattern. Setting `run_i` again starts at state 0.
- R3: When `run_i`=1 and `manual_i`=0, an accepted advance moves the state 0→1→2→3→4→5→0. Without an accepted advance the state holds.
- R4: A free-running cycle counter starts at 0 on the first edge after reset. An advance pulse is accepted only at an edge where that counter is a multiple of 1, 2, 4 or 8, for `presc_i` = 0, 1, 2 or 3 respectively.
- R5: When `run_i`=1 and `manual_i`=1, a `mcode_i` value from 0 to 5 becomes `state_o` on the next cycle, and the advance pulse is ignored. When `run_i`=0, `manual_i` has no effect.
- R6: In manual mode with `run_i`=1, a `mcode_i` of 6 or 7 leaves the state unchanged and sets `err_o`. `err_o` stays set until reset.
- R7: When `manual_i` falls while `run_i` stays 1, automatic stepping continues from the last manual state. An advance accepted on that same edge moves directly to the next step.
- R8: Phases A, B and C map to bits 0, 1 and 2 of `hs_o` and `ls_o`. The six states drive the following high/low pairs: 0: A/B, 1: A/C, 2: B/C, 3: B/A, 4: C/A, 5: C/B. The third phase floats, and no phase ever has both sides on.
- R9: `bias_o` is 1 exactly when the previous edge saw `run_i`=0 and `bias_en_i`=1. It is never 1 while the outputs are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| run_i | input | 1 | Run (1) / stop (0) |
| manual_i | input | 1 | Manual commutation select |
| mcode_i | input | 3 | Manual commutation code |
| bias_en_i | input | 1 | Centre-tap bias enable while stopped |
| presc_i | input | 2 | Prescaler factor (divide by 1, 2, 4, 8) |
| adv_i | input | 1 | Advance pulse from back-EMF timing |
| state_o | output | 3 | Current commutation state |
| hs_o | output | 3 | High-side enables, phases C..A |
| ls_o | output | 3 | Low-side enables, phases C..A |
| off_o | output | 1 | All phase outputs off |
| bias_o | output | 1 | Centre-tap bias request |
| err_o | output | 1 | Sticky invalid-manual-code flag |

## Verification
Two functions can fall on the same edge: the hand-back from manual to automatic mode, and an advance pulse that lands on a prescaled tick. The bench provokes this by dropping `manual_i` from code 3 while `adv_i` is held high at divide-by-1. It expects state 4 on the next cycle, not 3, and not a restart. A second collision pairs an invalid manual code with a live advance; there the bench expects the held state and a raised error flag. A behavioural model, stepped with the same inputs, judges every cycle. Long random runs let these coincidences recur under all four prescaler settings.

// File: rtl/spin_commutator.sv
module spin_commutator #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          manual_i,
  input  logic [2:0]    mcode_i,
  input  logic          bias_en_i,
  input  logic [PW-1:0] presc_i,
  input  logic          adv_i,
  output logic [2:0]    state_o,
  output logic [2:0]    hs_o,
  output logic [2:0]    ls_o,
  output logic          off_o,
  output logic          bias_o,
  output logic          err_o
);
  localparam int CW = (1 << PW) - 1;

  logic [CW-1:0] cnt, mask;
  logic          tick, bad;
  logic [2:0]    st_n, hs_n, ls_n;

  assign mask = ~({CW{1'b1}} << presc_i);
  assign tick = (cnt & mask) == '0;
  assign bad  = run_i && manual_i && (mcode_i > 3'd5);

  always_comb begin
    st_n = state_o;
    if (!run_i)
      st_n = 3'd0;
    else if (manual_i) begin
      if (!bad) st_n = mcode_i;
    end else if (adv_i && tick)
      st_n = (state_o == 3'd5) ? 3'd0 : state_o + 3'd1;
  end

  always_comb begin
    hs_n = 3'b000;
    ls_n = 3'b000;
    case (st_n)
      3'd0: begin hs_n = 3'b001; ls_n = 3'b010; end
      3'd1: begin hs_n = 3'b001; ls_n = 3'b100; end
      3'd2: begin hs_n = 3'b010; ls_n = 3'b100; end
      3'd3: begin hs_n = 3'b010; ls_n = 3'b001; end
      3'd4: begin hs_n = 3'b100; ls_n = 3'b001; end
      3'd5: begin hs_n = 3'b100; ls_n = 3'b010; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      state_o <= 3'd0;
      hs_o    <= 3'b000;
      ls_o    <= 3'b000;
      off_o   <= 1'b1;
      bias_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      state_o <= st_n;
      hs_o    <= run_i ? hs_n : 3'b000;
      ls_o    <= run_i ? ls_n : 3'b000;
      off_o   <= !run_i;
      bias_o  <= bias_en_i && !run_i;
      err_o   <= err_o || bad;
    end
  end

  // R8
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_o & ls_o) == 3'b000);

  // R8
  one_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !off_o |-> ($countones(hs_o) == 1 && $countones(ls_o) == 1));

  // R2
  float_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_o |-> (hs_o == 3'b000 && ls_o == 3'b000 && state_o == 3'd0));

  // R3
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R6
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && manual_i && mcode_i > 3'd5) |=> ($stable(state_o) && err_o));

  // R9
  bias_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bias_o |-> off_o);
endmodule

// File: tb/tb_spin_commutator.sv
module tb_spin_commutator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0, manual_i = 1'b0, bias_en_i = 1'b0, adv_i = 1'b0;
  logic [2:0] mcode_i = 3'd0;
  logic [1:0] presc_i = 2'd0;
  logic [2:0] state_o, hs_o, ls_o;
  logic off_o, bias_o, err_o;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string ph = "R1";

  int m_state = 0, m_on = 0, m_bias = 0, m_err = 0, m_cnt = 0;

  always #5 clk = ~clk;

  spin_commutator dut (.*);

  function automatic int exp_hs(int s, int on);
    if (!on) return 0;
    return 1 << (s / 2);
  endfunction

  function automatic int exp_ls(int s, int on);
    int lo [6] = '{1, 2, 2, 0, 0, 1};
    if (!on) return 0;
    return 1 << lo[s];
  endfunction

  task automatic chk(string sig, string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s [%s] actual %0d expected %0d at %0t", req, sig, ph, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("state_o", "R3", int'(state_o), m_state);
    chk("hs_o", "R8", int'(hs_o), exp_hs(m_state, m_on));
    chk("ls_o", "R8", int'(ls_o), exp_ls(m_state, m_on));
    chk("off_o", "R2", int'(off_o), m_on ? 0 : 1);
    chk("bias_o", "R9", int'(bias_o), m_bias);
    chk("err_o", "R6", int'(err_o), m_err);
  endtask

  task automatic cyc(bit rst, bit run, bit man, int code, bit bias, int pr, bit adv);
    @(negedge clk);
    compare_all();
    rst_n = rst; run_i = run; manual_i = man; mcode_i = code[2:0];
    bias_en_i = bias; presc_i = pr[1:0]; adv_i = adv;
    if (!rst) begin
      m_state = 0; m_on = 0; m_bias = 0; m_err = 0; m_cnt = 0;
    end else begin
      if (!run) m_state = 0;
      else if (man) begin
        if (code < 6) m_state = code; else m_err = 1;
      end else if (adv && (m_cnt % (1 << pr)) == 0)
        m_state = (m_state + 1) % 6;
      m_on = run;
      m_bias = (bias && !run) ? 1 : 0;
      m_cnt++;
    end
  endtask

  initial begin
    // R1 reset values
    ph = "R1";
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 4, 1, 0, 1);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // R2 start at state 0
    ph = "R2";
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 0, 0);
    // R3 wrap at divide by 1
    ph = "R3";
    for (int i = 0; i < 9; i++) cyc(1, 1, 0, 0, 0, 0, 1);
    // R4 each prescaler with adv held high
    ph = "R4";
    for (int p = 1; p < 4; p++)
      for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0, 0, p, 1);
    ph = "R4 single pulses";
    for (int i = 0; i < 24; i++) cyc(1, 1, 0, 0, 0, 2, (i % 3) == 0);
    // R5 manual codes, adv ignored
    ph = "R5";
    for (int c = 0; c < 6; c++) cyc(1, 1, 1, 5 - c, 0, 0, 1);
    ph = "R5 manual without run";
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 4, 0, 0, 1);
    // R7 manual release coinciding with advance
    ph = "R7";
    cyc(1, 1, 1, 3, 0, 0, 0);
    cyc(1, 1, 1, 3, 0, 0, 0);
    cyc(1, 1, 0, 3, 0, 0, 1);
    cyc(1, 1, 0, 3, 0, 0, 0);
    cyc(1, 1, 0, 3, 0, 0, 0);
    // R6 invalid codes with live advance
    ph = "R6";
    cyc(1, 1, 1, 2, 0, 0, 1);
    cyc(1, 1, 1, 6, 0, 0, 1);
    cyc(1, 1, 1, 7, 0, 0, 1);
    cyc(1, 1, 1, 1, 0, 0, 1);
    cyc(1, 1, 1, 1, 0, 0, 1);
    // R9 stop with and without bias
    ph = "R9";
    cyc(1, 0, 0, 0, 1, 0, 1);
    cyc(1, 0, 0, 0, 1, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 1, 0, 0);
    cyc(1, 1, 0, 0, 1, 0, 0);
    // R1 reset clears sticky error
    ph = "R1 re-reset";
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // random mix over all modes
    ph = "R3 R4 R5 R7 random";
    for (int i = 0; i < 3000; i++) begin
      bit rn, mn;
      rn = ($urandom % 10) != 0;
      mn = ($urandom % 4) == 0;
      cyc(1, rn, mn, $urandom % 8, $urandom % 2, $urandom % 4, $urandom % 2);
    end
    cyc(1, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule